// File: doc/BRIEF.md
# Standby Entry and Wake-Up Sequencer

This block decides whether the core clocks keep running when the processor executes its sleep instruction. If the standby enable bit of its small configuration register is set, a sleep strobe takes the controller into a gated state and drops the clock enable. If the bit is clear, the same strobe only parks the processor in an ordinary halt, with the clocks still running. Out of the gated state, an interrupt request always starts the wake-up sequence. An active-low bus request starts it only when its own enable bit allows.

Clocks are not restored as soon as the wake event is seen. The controller first runs a warm-up counter whose length is one of four powers of two, picked by a two-bit field. Clock enable and the running status come back only when that count has expired. While the counter runs, further wake events, sleep strobes and register writes cannot shorten or lengthen the delay. Reset returns the controller to normal operation at once.

Top module: `standby_ctrl`

## Requirements
- R1: Reset puts the block in normal operation: clk_en_o = 1 and running_o = 1. The configuration register resets to all zeros, so standby stays disabled until it is written.
- R2: The configuration register is 4 bits wide. It loads from cfg_wdata_i on a clock edge when cfg_we_i = 1. Bit 0 enables standby, bit 1 enables bus request as a wake source, and bits [3:2] select the warm-up length.
- R3: With bit 0 = 1, a sleep_i strobe during normal operation drives clk_en_o and running_o low from the next cycle.
- R4: With bit 0 = 0, a sleep_i strobe gives a halt. clk_en_o stays 1 and running_o goes to 0. Only irq_i = 1 ends the halt, with running_o high the next cycle. A low busreq_ni has no effect on the halt.
- R5: In standby, irq_i = 1 starts the warm-up from the next cycle, and clk_en_o stays 0.
- R6: In standby, busreq_ni = 0 starts the warm-up only when bit 1 = 1. When bit 1 = 0 it is ignored and the clocks stay gated.
- R7: The warm-up lasts exactly 2^(WARM_BASE_LOG2 + WARM_STEP_LOG2*sel) cycles, where sel is taken from bits [3:2] at the wake edge. With the defaults this gives 16, 64, 256 or 1024 cycles. After that count, clk_en_o and running_o are both 1.
- R8: During the warm-up, irq_i, busreq_ni, sleep_i and configuration writes do not change its length.
- R9: running_o is never 1 while clk_en_o is 0, and sleep_i is ignored outside normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 4 | Configuration write data |
| sleep_i | input | 1 | One-cycle strobe: sleep instruction executed |
| irq_i | input | 1 | Interrupt request, active high |
| busreq_ni | input | 1 | Bus request, active low |
| clk_en_o | output | 1 | Enable for the downstream clock gates |
| running_o | output | 1 | Processor is running normally |

## Verification
The bench holds a bus request low while its wake enable is off. A design that decodes the enable bit wrongly would leave standby in that window, or would end a plain halt. Every warm-up is timed to the exact cycle for all four length codes, so an off-by-one counter, or a wrong shift for the selected length, shows up as clock enable rising one cycle early or late. During some warm-ups the bench also toggles the wake inputs and the sleep strobe and rewrites the length field. A design that restarted its counter, or reloaded it with the new length, would miss the expected release cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int CFG_W = 4;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HALT    = 2'd1,
        ST_STANDBY = 2'd2,
        ST_WARMUP  = 2'd3
    } stby_state_e;

    // bit0: standby enable, bit1: bus-request wake enable, bits[3:2]: warm-up select
    typedef struct packed {
        logic [1:0] warm_sel;
        logic       bus_wake_en;
        logic       stby_en;
    } stby_cfg_t;

    typedef struct packed {
        stby_state_e state;
    } stby_fsm_t;

endpackage

// File: rtl/stby_cfg_reg.sv
module stby_cfg_reg
    import stby_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output stby_cfg_t        cfg_o
);

    stby_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d = stby_cfg_t'(wdata_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/stby_wake_src.sv
module stby_wake_src
    import stby_pkg::*;
(
    input  stby_cfg_t cfg_i,
    input  logic      irq_i,
    input  logic      busreq_ni,
    output logic      stby_wake_o,
    output logic      halt_wake_o
);

    logic bus_wake;

    always_comb begin
        bus_wake    = cfg_i.bus_wake_en & ~busreq_ni;
        stby_wake_o = irq_i | bus_wake;
        halt_wake_o = irq_i;
    end

endmodule

// File: rtl/stby_warm_timer.sv
module stby_warm_timer #(
    parameter int WARM_BASE_LOG2 = 4,
    parameter int WARM_STEP_LOG2 = 2,
    parameter int CNT_W          = WARM_BASE_LOG2 + 3 * WARM_STEP_LOG2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic [1:0] sel_i,
    input  logic       run_i,
    output logic       done_o
);

    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [LEN_W-1:0] load_val;

    always_comb begin
        load_val = (LEN_W'(1) << (WARM_BASE_LOG2 + WARM_STEP_LOG2 * int'(sel_i)))
                   - LEN_W'(1);
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val[CNT_W-1:0];
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import stby_pkg::*;
#(
    parameter int WARM_BASE_LOG2 = 4,
    parameter int WARM_STEP_LOG2 = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             sleep_i,
    input  logic             irq_i,
    input  logic             busreq_ni,
    output logic             clk_en_o,
    output logic             running_o
);

    localparam int CNT_W = WARM_BASE_LOG2 + 3 * WARM_STEP_LOG2;

    stby_cfg_t   cfg_q;
    stby_fsm_t   fsm_d, fsm_q;
    stby_state_e state_q;
    logic        stby_wake, halt_wake;
    logic        warm_load, warm_done;

    stby_cfg_reg u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg_q)
    );

    stby_wake_src u_wake (
        .cfg_i       (cfg_q),
        .irq_i       (irq_i),
        .busreq_ni   (busreq_ni),
        .stby_wake_o (stby_wake),
        .halt_wake_o (halt_wake)
    );

    stby_warm_timer #(
        .WARM_BASE_LOG2 (WARM_BASE_LOG2),
        .WARM_STEP_LOG2 (WARM_STEP_LOG2),
        .CNT_W          (CNT_W)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (warm_load),
        .sel_i  (cfg_q.warm_sel),
        .run_i  (fsm_q.state == ST_WARMUP),
        .done_o (warm_done)
    );

    assign state_q = fsm_q.state;

    always_comb begin
        fsm_d     = fsm_q;
        warm_load = 1'b0;
        unique case (fsm_q.state)
            ST_RUN: begin
                if (sleep_i) begin
                    fsm_d.state = cfg_q.stby_en ? ST_STANDBY : ST_HALT;
                end
            end
            ST_HALT: begin
                if (halt_wake) begin
                    fsm_d.state = ST_RUN;
                end
            end
            ST_STANDBY: begin
                if (stby_wake) begin
                    fsm_d.state = ST_WARMUP;
                    warm_load   = 1'b1;
                end
            end
            ST_WARMUP: begin
                if (warm_done) begin
                    fsm_d.state = ST_RUN;
                end
            end
            default: fsm_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q.state <= ST_RUN;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign clk_en_o  = (fsm_q.state == ST_RUN) || (fsm_q.state == ST_HALT);
    assign running_o = (fsm_q.state == ST_RUN);

endmodule

// File: rtl/stby_checker.sv
module stby_checker
    import stby_pkg::*;
#(
    parameter int WARM_BASE_LOG2 = 4,
    parameter int WARM_STEP_LOG2 = 2
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        sleep_i,
    input logic        irq_i,
    input logic        busreq_ni,
    input logic        clk_en_o,
    input logic        running_o,
    input stby_state_e state_q,
    input stby_cfg_t   cfg_q
);

    localparam int LEN_W = WARM_BASE_LOG2 + 3 * WARM_STEP_LOG2 + 1;

    logic [LEN_W-1:0] chk_cnt, exp_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chk_cnt <= '0;
            exp_len <= '0;
        end else begin
            chk_cnt <= (state_q == ST_WARMUP) ? chk_cnt + LEN_W'(1) : '0;
            if (state_q == ST_STANDBY) begin
                exp_len <= LEN_W'(1) << (WARM_BASE_LOG2 + WARM_STEP_LOG2 * int'(cfg_q.warm_sel));
            end
        end
    end

    AST_GATE_ON_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && sleep_i && cfg_q.stby_en) |=> (!clk_en_o && !running_o)); // R3
    AST_HALT_KEEPS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && sleep_i && !cfg_q.stby_en) |=> (clk_en_o && !running_o)); // R4
    AST_HALT_IRQ_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HALT && irq_i) |=> running_o); // R4
    AST_HALT_BUS_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HALT && !irq_i) |=> (state_q == ST_HALT)); // R4
    AST_IRQ_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STANDBY && irq_i) |=> (state_q == ST_WARMUP && !clk_en_o)); // R5
    AST_BUS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STANDBY && !irq_i && !cfg_q.bus_wake_en) |=> (state_q == ST_STANDBY)); // R6
    AST_BUS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STANDBY && !busreq_ni && cfg_q.bus_wake_en) |=> (state_q == ST_WARMUP)); // R6
    AST_WARM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WARMUP && (chk_cnt + LEN_W'(1)) < exp_len) |=> (state_q == ST_WARMUP)); // R8
    AST_WARM_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WARMUP && (chk_cnt + LEN_W'(1)) == exp_len) |=> (running_o && clk_en_o)); // R7
    AST_RUN_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_o |-> clk_en_o); // R9

endmodule

bind standby_ctrl stby_checker #(
    .WARM_BASE_LOG2 (WARM_BASE_LOG2),
    .WARM_STEP_LOG2 (WARM_STEP_LOG2)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .irq_i     (irq_i),
    .busreq_ni (busreq_ni),
    .clk_en_o  (clk_en_o),
    .running_o (running_o),
    .state_q   (state_q),
    .cfg_q     (cfg_q)
);

// File: tb/standby_ctrl_tb_top.sv
module standby_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [3:0] cfg_wdata;
    logic       sleep, irq, busreq_n;
    logic       clk_en, running;
    int         n_tests = 0;
    int         n_fail  = 0;
    int         cyc     = 0;

    always #2 clk = ~clk;

    standby_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .sleep_i     (sleep),
        .irq_i       (irq),
        .busreq_ni   (busreq_n),
        .clk_en_o    (clk_en),
        .running_o   (running)
    );

    function automatic int warm_len(int sel);
        return 1 << (4 + 2 * sel);
    endfunction

    task automatic chk(string req, string what, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(bit en, bit bus, int sel);
        cfg_we    = 1'b1;
        cfg_wdata = {2'(sel), bus, en};
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep = 1'b1;
        tick();
        sleep = 1'b0;
    endtask

    // called at the negedge right after the warm-up was entered
    task automatic measure(int sel, bit noisy);
        int n = warm_len(sel);
        for (int i = 1; i < n; i++) begin
            if (noisy) begin
                irq       = 1'($urandom);
                busreq_n  = 1'($urandom);
                sleep     = 1'($urandom);
                cfg_we    = ($urandom % 4) == 0;
                cfg_wdata = 4'($urandom);
            end
            tick();
            if (i == 1 || i == n - 1) begin
                chk(noisy ? "R8" : "R7", "clk_en held low in warm-up", clk_en, 1'b0);
                chk("R9", "running low in warm-up", running, 1'b0);
            end
        end
        irq = 1'b0; busreq_n = 1'b1; sleep = 1'b0; cfg_we = 1'b0;
        tick();
        chk(noisy ? "R8" : "R7", "clk_en back after warm-up", clk_en, 1'b1);
        chk("R7", "running back after warm-up", running, 1'b1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        sleep = 1'b0; irq = 1'b0; busreq_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "clk_en in reset", clk_en, 1'b1);
        rst_n = 1'b1;
        tick();
        chk("R1", "clk_en after reset", clk_en, 1'b1);
        chk("R1", "running after reset", running, 1'b1);

        // R1 / R4: config cleared by reset, so sleep only halts
        pulse_sleep();
        chk("R4", "clk_en during halt", clk_en, 1'b1);
        chk("R4", "running during halt", running, 1'b0);
        busreq_n = 1'b0;
        repeat (5) tick();
        busreq_n = 1'b1;
        chk("R4", "bus request ignored in halt", running, 1'b0);
        irq = 1'b1; tick(); irq = 1'b0;
        chk("R4", "irq ends halt", running, 1'b1);

        // R2 / R3 / R6 / R5: standby, bus wake masked, irq wake
        wr_cfg(1'b1, 1'b0, 0);
        pulse_sleep();
        chk("R3", "clk_en gated after sleep", clk_en, 1'b0);
        chk("R3", "running low after sleep", running, 1'b0);
        busreq_n = 1'b0;
        repeat (5) tick();
        busreq_n = 1'b1;
        chk("R6", "masked bus request keeps gating", clk_en, 1'b0);
        pulse_sleep();
        chk("R9", "sleep ignored in standby", clk_en, 1'b0);
        irq = 1'b1; tick(); irq = 1'b0;
        chk("R5", "irq starts warm-up with clocks still off", clk_en, 1'b0);
        measure(0, 1'b0);

        // R6: bus wake enabled, longest length
        wr_cfg(1'b1, 1'b1, 3);
        pulse_sleep();
        busreq_n = 1'b0; tick(); busreq_n = 1'b1;
        chk("R6", "enabled bus request starts warm-up", clk_en, 1'b0);
        measure(3, 1'b0);

        // R8: noise during warm-up, length fixed at wake
        wr_cfg(1'b1, 1'b0, 1);
        pulse_sleep();
        irq = 1'b1; tick(); irq = 1'b0;
        measure(1, 1'b1);

        // randomized trials
        for (int t = 0; t < 24; t++) begin
            bit en  = 1'($urandom);
            bit bus = 1'($urandom);
            int sel = int'($urandom % 3);
            bit use_bus = 1'($urandom);
            wr_cfg(en, bus, sel);
            chk("R2", "write leaves running", running, 1'b1);
            pulse_sleep();
            if (!en) begin
                chk("R4", "halt keeps clk_en", clk_en, 1'b1);
                chk("R4", "halt drops running", running, 1'b0);
                busreq_n = 1'b0; repeat (3) tick(); busreq_n = 1'b1;
                chk("R4", "bus request ignored in halt", running, 1'b0);
                irq = 1'b1; tick(); irq = 1'b0;
                chk("R4", "irq ends halt", running, 1'b1);
            end else begin
                chk("R3", "sleep gates clocks", clk_en, 1'b0);
                if (use_bus && !bus) begin
                    busreq_n = 1'b0; repeat (3) tick(); busreq_n = 1'b1;
                    chk("R6", "masked bus request ignored", clk_en, 1'b0);
                    use_bus = 1'b0;
                end
                if (use_bus) begin
                    busreq_n = 1'b0; tick(); busreq_n = 1'b1;
                end else begin
                    irq = 1'b1; tick(); irq = 1'b0;
                end
                chk("R5", "wake leaves clocks off", clk_en, 1'b0);
                measure(sel, 1'($urandom));
            end
        end

        // R1: reset in the middle of standby restores operation at once
        wr_cfg(1'b1, 1'b0, 2);
        pulse_sleep();
        rst_n = 1'b0;
        #1;
        chk("R1", "reset restores clk_en", clk_en, 1'b1);
        chk("R1", "reset restores running", running, 1'b1);
        tick();
        rst_n = 1'b1;
        tick();
        pulse_sleep();
        chk("R1", "config cleared by reset", clk_en, 1'b1);
        irq = 1'b1; tick(); irq = 1'b0;
        chk("R4", "irq ends halt after reset", running, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule